// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core with five stages: fetch, decode with register read, execute, memory access and write-back. It runs a small instruction subset: word load, word store, register-to-register ALU operations and a branch taken when two registers are equal. Pipeline registers sit between neighbouring stages. A new instruction is fetched on every cycle, and there is no stall, interlock or operand bypass. Software must therefore keep producers and consumers far enough apart, and it must fill the three slots that follow every branch.

The instruction memory and the data memory are word arrays held inside the block. A load port writes either of them, and the surrounding system uses it to place a program and its data while reset is held. The block shows its progress on three sets of outputs: the fetch address, the register-file write port and the data-memory write port. Every instruction class that writes a register does so in stage 5. An ALU result therefore passes through an idle memory stage, which means at most one register write can happen in any cycle.

Top module: `pipe5_core`

## Requirements
- R1: Reset is synchronous. While it is held, and in the first cycle after it is released, `pc_o` is 0 and `wb_we` and `st_we` are 0. The first instruction's write-back appears on the fourth clock edge after release.
- R2: An ALU instruction has opcode bits [31:26] = 0, bits [10:6] = 0, sources rs = bits [25:21] and rt = bits [20:16], and destination rd = bits [15:11]. Function bits [5:0] select the operation: 0 add, 1 subtract (rs minus rt), 2 and, 3 or, 4 xor, 5 signed less-than giving 1 or 0. The result is written only in stage 5.
- R3: Register 0 always reads as zero. A write aimed at register 0 raises no `wb_we`.
- R4: A load has opcode 1. Its address is rs plus the sign-extended bits [15:0]. The data word index is address bits [MEM_AW+1:2], so the index wraps modulo the memory size. The word read is written to rt in stage 5.
- R5: A store has opcode 2. It writes the value of rt to the word at the address formed as in R4. The write is shown on `st_we`/`st_addr`/`st_data` during the memory stage, and no register write follows in the next cycle.
- R6: Write-backs leave the block in program order, at most one per cycle. Loads and ALU instructions use the same stage.
- R7: A branch has opcode 3. When rs equals rt, the fetch address is loaded with PC+4 plus the sign-extended bits [15:0] shifted left by 2, at the end of the branch's memory stage. The three instructions after the branch always complete, and the instructions between those three and the target never do.
- R8: A branch whose operands differ does not redirect. The fetch address keeps rising by 4 every cycle.
- R9: Registers are read in decode, and a read returns the value held before a write on the same edge. The three instructions after a producer see the old value, and the fourth sees the new one.
- R10: An undefined opcode, or an ALU instruction with an undefined function or non-zero bits [10:6], writes no register, stores nothing and does not redirect.
- R11: When `load_en` is 1, `load_sel` = 0 writes `load_data` into instruction word `load_addr` and `load_sel` = 1 writes it into data word `load_addr`. A store in the same cycle takes priority over the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load-port write strobe |
| load_sel | input | 1 | Load-port target: 0 instruction memory, 1 data memory |
| load_addr | input | MEM_AW | Word index for the load port |
| load_data | input | XLEN | Word written by the load port |
| pc_o | output | XLEN | Address being fetched this cycle |
| wb_we | output | 1 | Register write in this cycle |
| wb_reg | output | 5 | Destination register of the write |
| wb_data | output | XLEN | Value written to the register |
| st_we | output | 1 | Data-memory store in this cycle |
| st_addr | output | XLEN | Byte address of the store |
| st_data | output | XLEN | Word stored |

## Verification
The hardest situation to reach is the three-instruction window after a load or an ALU producer. In that window a consumer reads the stale register value, and this happens only when the instruction distance is exactly one to three. The bench's program places consumers at distances 1, 2, 3, 4 and more from two back-to-back loads. One of them uses a stale base register to form a negative address that wraps into the top data word. A taken forward branch, a not-taken branch and a self-targeting halt loop then test redirect timing. In that halt loop, an undefined opcode and an undefined function sit in the delay slots and repeat indefinitely, and they must never produce an event.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

   localparam int unsigned REG_AW = 5;

   typedef enum logic [5:0] {
      OP_ALU   = 6'd0,
      OP_LOAD  = 6'd1,
      OP_STORE = 6'd2,
      OP_BEQ   = 6'd3
   } op_e;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_XOR = 3'd4,
      ALU_SLT = 3'd5
   } alu_e;

   typedef struct packed {
      logic reg_wr;
      logic mem_rd;
      logic mem_wr;
      logic branch;
      logic use_imm;
      alu_e alu_op;
   } ctrl_t;

   localparam ctrl_t CTRL_NOP = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                                  branch: 1'b0, use_imm: 1'b0, alu_op: ALU_ADD};

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
   import pipe5_pkg::*;
(
   input  logic [31:0]       instr,
   output ctrl_t             ctrl,
   output logic [REG_AW-1:0] dest
);
   logic fn_ok;
   alu_e fn_op;

   always_comb begin
      fn_ok = (instr[10:6] == 5'd0);
      fn_op = ALU_ADD;
      unique case (instr[5:0])
         6'd0:    fn_op = ALU_ADD;
         6'd1:    fn_op = ALU_SUB;
         6'd2:    fn_op = ALU_AND;
         6'd3:    fn_op = ALU_OR;
         6'd4:    fn_op = ALU_XOR;
         6'd5:    fn_op = ALU_SLT;
         default: fn_ok = 1'b0;
      endcase
   end

   always_comb begin
      ctrl = CTRL_NOP;
      dest = instr[20:16];
      case (op_e'(instr[31:26]))
         OP_ALU: begin
            ctrl.reg_wr = fn_ok;
            ctrl.alu_op = fn_op;
            dest        = instr[15:11];
         end
         OP_LOAD: begin
            ctrl.reg_wr  = 1'b1;
            ctrl.mem_rd  = 1'b1;
            ctrl.use_imm = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_wr  = 1'b1;
            ctrl.use_imm = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         default: ctrl = CTRL_NOP;
      endcase
   end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
   import pipe5_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_e            op,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_XOR: y = a ^ b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
   parameter int unsigned XLEN           = 32,
   parameter int unsigned AW             = 5,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [AW-1:0]   ra,
   input  logic [AW-1:0]   rb,
   output logic [XLEN-1:0] da,
   output logic [XLEN-1:0] db,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd
);
   localparam int unsigned NREGS = 1 << AW;

   logic [XLEN-1:0] regs_q [NREGS];
   logic            wr_ok;

   assign wr_ok = we && (wa != '0);

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
         end else if (wr_ok) begin
            regs_q[wa] <= wd;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_ok) regs_q[wa] <= wd;
      end
   end

   assign da = (ra == '0) ? '0 : regs_q[ra];
   assign db = (rb == '0) ? '0 : regs_q[rb];
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned MEM_AW   = 6,
   parameter bit          RF_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic              load_sel,
   input  logic [MEM_AW-1:0] load_addr,
   input  logic [XLEN-1:0]   load_data,
   output logic [XLEN-1:0]   pc_o,
   output logic              wb_we,
   output logic [REG_AW-1:0] wb_reg,
   output logic [XLEN-1:0]   wb_data,
   output logic              st_we,
   output logic [XLEN-1:0]   st_addr,
   output logic [XLEN-1:0]   st_data
);
   localparam int unsigned MEM_WORDS = 1 << MEM_AW;
   localparam int unsigned IDX_LSB   = 2;
   localparam int unsigned IMM_W     = 16;

   if (XLEN != 32) begin : g_bad_xlen
      $error("pipe5_core: instruction format requires XLEN == 32");
   end
   if (MEM_AW < 2 || MEM_AW > 12) begin : g_bad_aw
      $error("pipe5_core: MEM_AW must lie in 2..12");
   end

   typedef struct packed {
      logic [XLEN-1:0] instr;
      logic [XLEN-1:0] pc4;
   } ifid_t;

   typedef struct packed {
      ctrl_t             ctrl;
      logic [REG_AW-1:0] dest;
      logic [XLEN-1:0]   a;
      logic [XLEN-1:0]   b;
      logic [XLEN-1:0]   imm;
      logic [XLEN-1:0]   pc4;
   } idex_t;

   typedef struct packed {
      logic              reg_wr;
      logic              mem_rd;
      logic              mem_wr;
      logic              take;
      logic [REG_AW-1:0] dest;
      logic [XLEN-1:0]   res;
      logic [XLEN-1:0]   sdata;
      logic [XLEN-1:0]   tgt;
   } exmem_t;

   typedef struct packed {
      logic              reg_wr;
      logic              mem_rd;
      logic [REG_AW-1:0] dest;
      logic [XLEN-1:0]   res;
      logic [XLEN-1:0]   ldata;
   } memwb_t;

   logic [XLEN-1:0] imem [MEM_WORDS];
   logic [XLEN-1:0] dmem [MEM_WORDS];

   logic [XLEN-1:0] pc_q, pc_plus4;
   ifid_t           ifid_q;
   idex_t           idex_q;
   exmem_t          exmem_q;
   memwb_t          memwb_q;

   logic            redirect;
   logic [XLEN-1:0] redirect_pc;

   // ---------------- fetch
   assign pc_plus4    = pc_q + XLEN'(4);
   assign redirect    = exmem_q.take;
   assign redirect_pc = exmem_q.tgt;

   always_ff @(posedge clk) begin
      if (load_en && !load_sel) imem[load_addr] <= load_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         ifid_q <= '0;
      end else begin
         ifid_q.instr <= imem[pc_q[IDX_LSB +: MEM_AW]];
         ifid_q.pc4   <= pc_plus4;
         pc_q         <= redirect ? redirect_pc : pc_plus4;
      end
   end

   // ---------------- decode / register read
   ctrl_t             dec_ctrl;
   logic [REG_AW-1:0] dec_dest;
   logic [XLEN-1:0]   rs_val, rt_val;

   pipe5_decode u_dec (
      .instr (ifid_q.instr),
      .ctrl  (dec_ctrl),
      .dest  (dec_dest)
   );

   pipe5_regfile #(.XLEN(XLEN), .AW(REG_AW), .CLEAR_ON_RESET(RF_CLEAR)) u_rf (
      .clk (clk),
      .rst (rst),
      .ra  (ifid_q.instr[25:21]),
      .rb  (ifid_q.instr[20:16]),
      .da  (rs_val),
      .db  (rt_val),
      .we  (wb_we),
      .wa  (memwb_q.dest),
      .wd  (wb_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         idex_q      <= '0;
         idex_q.ctrl <= CTRL_NOP;
      end else begin
         idex_q.ctrl <= dec_ctrl;
         idex_q.dest <= dec_dest;
         idex_q.a    <= rs_val;
         idex_q.b    <= rt_val;
         idex_q.imm  <= {{(XLEN-IMM_W){ifid_q.instr[IMM_W-1]}}, ifid_q.instr[IMM_W-1:0]};
         idex_q.pc4  <= ifid_q.pc4;
      end
   end

   // ---------------- execute
   logic [XLEN-1:0] alu_b, alu_y, br_tgt;
   logic            alu_zero;

   assign alu_b  = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.b;
   assign br_tgt = idex_q.pc4 + (idex_q.imm << 2);

   pipe5_alu #(.XLEN(XLEN)) u_alu (
      .a    (idex_q.a),
      .b    (alu_b),
      .op   (idex_q.ctrl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         exmem_q <= '0;
      end else begin
         exmem_q.reg_wr <= idex_q.ctrl.reg_wr;
         exmem_q.mem_rd <= idex_q.ctrl.mem_rd;
         exmem_q.mem_wr <= idex_q.ctrl.mem_wr;
         exmem_q.take   <= idex_q.ctrl.branch && alu_zero;
         exmem_q.dest   <= idex_q.dest;
         exmem_q.res    <= alu_y;
         exmem_q.sdata  <= idex_q.b;
         exmem_q.tgt    <= br_tgt;
      end
   end

   // ---------------- memory access
   logic [MEM_AW-1:0] d_idx;
   assign d_idx = exmem_q.res[IDX_LSB +: MEM_AW];

   always_ff @(posedge clk) begin
      if (exmem_q.mem_wr)          dmem[d_idx]     <= exmem_q.sdata;
      else if (load_en && load_sel) dmem[load_addr] <= load_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         memwb_q <= '0;
      end else begin
         memwb_q.reg_wr <= exmem_q.reg_wr;
         memwb_q.mem_rd <= exmem_q.mem_rd;
         memwb_q.dest   <= exmem_q.dest;
         memwb_q.res    <= exmem_q.res;
         memwb_q.ldata  <= dmem[d_idx];
      end
   end

   // ---------------- write-back and observation
   assign wb_we   = memwb_q.reg_wr && (memwb_q.dest != '0);
   assign wb_reg  = memwb_q.dest;
   assign wb_data = memwb_q.mem_rd ? memwb_q.ldata : memwb_q.res;
   assign st_we   = exmem_q.mem_wr;
   assign st_addr = exmem_q.res;
   assign st_data = exmem_q.sdata;
   assign pc_o    = pc_q;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] pc_o,
   input logic            wb_we,
   input logic            st_we,
   input logic            redirect,
   input logic [XLEN-1:0] redirect_pc
);
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_o == '0 && !wb_we && !st_we));

   p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
      st_we |=> !wb_we);

   p_redirect_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(redirect)) |-> pc_o == $past(redirect_pc));

   p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(redirect)) |-> pc_o == $past(pc_o) + XLEN'(4));

   p_wb_quiet_in_reset_r1: assert property (@(posedge clk)
      rst |=> (pc_o == '0));
endmodule

bind pipe5_core pipe5_core_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .pc_o        (pc_o),
   .wb_we       (wb_we),
   .st_we       (st_we),
   .redirect    (redirect),
   .redirect_pc (redirect_pc)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;
   localparam int unsigned XLEN   = 32;
   localparam int unsigned MEM_AW = 6;

   logic              clk = 1'b0;
   logic              rst;
   logic              load_en, load_sel;
   logic [MEM_AW-1:0] load_addr;
   logic [XLEN-1:0]   load_data;
   logic [XLEN-1:0]   pc_o, wb_data, st_addr, st_data;
   logic              wb_we, st_we;
   logic [4:0]        wb_reg;

   always #2 clk = ~clk;

   pipe5_core #(.XLEN(XLEN), .MEM_AW(MEM_AW)) i_pipe5_core (
      .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
      .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
      .wb_we(wb_we), .wb_reg(wb_reg), .wb_data(wb_data),
      .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit mon_en   = 1'b0;

   bit          q_st  [$];
   logic [31:0] q_a   [$];
   logic [31:0] q_d   [$];
   string       q_req [$];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push_wb(input int r, input logic [31:0] d, input string req);
      q_st.push_back(1'b0); q_a.push_back(32'(r)); q_d.push_back(d); q_req.push_back(req);
   endtask

   task automatic push_st(input logic [31:0] a, input logic [31:0] d, input string req);
      q_st.push_back(1'b1); q_a.push_back(a); q_d.push_back(d); q_req.push_back(req);
   endtask

   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [5:0] fn);
      return {6'd0, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // scoreboard monitor: write-back of the older instruction first, then the store
   always @(negedge clk) begin
      if (!rst && mon_en) begin
         if (cyc == 3) check(wb_we == 1'b0, "R1 no write-back before edge 4", 32'(wb_we), 32'd0);
         if (cyc == 4) check(wb_we == 1'b1, "R1 first write-back on edge 4", 32'(wb_we), 32'd1);
         if (wb_we) begin
            if (q_st.size() == 0 || q_st[0]) begin
               check(1'b0, "R7/R10 unexpected register write", {27'd0, wb_reg}, 32'hxxxxxxxx);
            end else begin
               check(wb_reg == q_a[0][4:0] && wb_data == q_d[0],
                     {q_req[0], " (reg)"}, {wb_reg, wb_data[26:0]}, {q_a[0][4:0], q_d[0][26:0]});
               check(wb_data == q_d[0], {q_req[0], " (data)"}, wb_data, q_d[0]);
               void'(q_st.pop_front()); void'(q_a.pop_front());
               void'(q_d.pop_front()); void'(q_req.pop_front());
            end
         end
         if (st_we) begin
            if (q_st.size() == 0 || !q_st[0]) begin
               check(1'b0, "R7/R10 unexpected store", st_addr, 32'hxxxxxxxx);
            end else begin
               check(st_addr == q_a[0], {q_req[0], " (addr)"}, st_addr, q_a[0]);
               check(st_data == q_d[0], {q_req[0], " (data)"}, st_data, q_d[0]);
               void'(q_st.pop_front()); void'(q_a.pop_front());
               void'(q_d.pop_front()); void'(q_req.pop_front());
            end
         end
      end
   end

   // fetch-address sequence around the branches
   logic [31:0] pc_prev = '0;
   always @(negedge clk) begin
      if (!rst && mon_en) begin
         if (pc_prev == 32'd72)  check(pc_o == 32'd84,  "R7 taken forward branch after 3 slots", pc_o, 32'd84);
         if (pc_prev == 32'd96)  check(pc_o == 32'd100, "R8 not-taken branch falls through", pc_o, 32'd100);
         if (pc_prev == 32'd112) check(pc_o == 32'd100, "R7 backward branch to itself", pc_o, 32'd100);
      end
      pc_prev = pc_o;
   end

   task automatic load_word(input bit sel, input int idx, input logic [31:0] d);
      @(negedge clk);
      load_en = 1'b1; load_sel = sel; load_addr = MEM_AW'(idx); load_data = d;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   logic [31:0] prog [64];

   initial begin
      rst = 1'b1; load_en = 1'b0; load_sel = 1'b0; load_addr = '0; load_data = '0;
      for (int i = 0; i < 64; i++) prog[i] = 32'd0;
      prog[0]  = enc_i(6'd1, 5'd0, 5'd1, 16'd0);        // lw r1,0(r0)
      prog[1]  = enc_i(6'd1, 5'd0, 5'd2, 16'd4);        // lw r2,4(r0)
      prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'd0);         // add r3,r1,r2
      prog[3]  = enc_r(5'd1, 5'd0, 5'd4, 6'd3);         // or r4,r1,r0
      prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'd0);         // add r5,r1,r2
      prog[5]  = enc_r(5'd2, 5'd1, 5'd6, 6'd1);         // sub r6,r2,r1
      prog[6]  = enc_r(5'd1, 5'd2, 5'd7, 6'd1);         // sub r7,r1,r2
      prog[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'd2);         // and r8,r1,r2
      prog[8]  = enc_r(5'd1, 5'd2, 5'd9, 6'd4);         // xor r9,r1,r2
      prog[9]  = enc_r(5'd7, 5'd1, 5'd10, 6'd5);        // slt r10,r7,r1
      prog[10] = enc_r(5'd1, 5'd2, 5'd0, 6'd0);         // add r0,r1,r2
      prog[11] = enc_r(5'd7, 5'd0, 5'd11, 6'd5);        // slt r11,r7,r0
      prog[12] = enc_r(5'd1, 5'd7, 5'd12, 6'd5);        // slt r12,r1,r7
      prog[13] = enc_i(6'd2, 5'd0, 5'd5, 16'd12);       // sw r5,12(r0)
      prog[14] = enc_i(6'd1, 5'd11, 5'd13, 16'hFFFC);   // lw r13,-4(r11)
      prog[15] = enc_i(6'd3, 5'd1, 5'd5, 16'd5);        // beq r1,r5 -> 84
      prog[16] = enc_r(5'd1, 5'd1, 5'd14, 6'd0);        // slot 1
      prog[17] = enc_r(5'd2, 5'd2, 5'd15, 6'd0);        // slot 2
      prog[18] = enc_r(5'd1, 5'd2, 5'd16, 6'd3);        // slot 3
      prog[19] = enc_r(5'd1, 5'd1, 5'd17, 6'd0);        // skipped
      prog[20] = enc_r(5'd2, 5'd2, 5'd18, 6'd0);        // skipped
      prog[21] = enc_i(6'd3, 5'd1, 5'd2, 16'd10);       // beq r1,r2 (not taken)
      prog[22] = enc_i(6'd2, 5'd0, 5'd8, 16'd16);       // sw r8,16(r0)
      prog[23] = enc_r(5'd1, 5'd0, 5'd19, 6'd0);        // add r19,r1,r0
      prog[24] = enc_i(6'd1, 5'd0, 5'd20, 16'd12);      // lw r20,12(r0)
      prog[25] = enc_i(6'd3, 5'd0, 5'd0, 16'hFFFF);     // beq r0,r0 -> itself
      prog[26] = enc_i(6'd9, 5'd1, 5'd22, 16'h1234);    // undefined opcode
      prog[27] = enc_r(5'd1, 5'd2, 5'd21, 6'd63);       // undefined function
      for (int i = 0; i < 64; i++) load_word(1'b0, i, prog[i]);
      load_word(1'b1, 0, 32'd5);
      load_word(1'b1, 1, 32'd7);
      load_word(1'b1, 63, 32'h0000_1234);

      // R1: state while reset is held
      check(pc_o == 32'd0, "R1 pc in reset", pc_o, 32'd0);
      check(wb_we == 1'b0 && st_we == 1'b0, "R1 writes idle in reset", {wb_we, st_we}, 32'd0);

      push_wb(1, 32'd5, "R4/R11 load r1");
      push_wb(2, 32'd7, "R4 load r2");
      push_wb(3, 32'd0, "R9 distance 1-2 see old");
      push_wb(4, 32'd0, "R9 distance 3 sees old");
      push_wb(5, 32'd5, "R9 distance 4 sees new");
      push_wb(6, 32'd2, "R2 sub");
      push_wb(7, 32'hFFFF_FFFE, "R2 sub negative");
      push_wb(8, 32'd5, "R2 and");
      push_wb(9, 32'd2, "R2 xor");
      push_wb(10, 32'd1, "R9 slt with stale operand");
      push_wb(11, 32'd1, "R2/R3 signed slt vs r0");
      push_wb(12, 32'd0, "R2 signed slt false");
      push_st(32'd12, 32'd5, "R5 store");
      push_wb(13, 32'h0000_1234, "R4 negative offset wraps");
      push_wb(14, 32'd10, "R7 delay slot 1");
      push_wb(15, 32'd14, "R7 delay slot 2");
      push_wb(16, 32'd7, "R7/R6 delay slot 3");
      push_st(32'd16, 32'd5, "R8/R5 store after not-taken");
      push_wb(19, 32'd5, "R8 fall-through");
      push_wb(20, 32'd5, "R5 load sees stored word");

      @(negedge clk);
      rst = 1'b0;
      mon_en = 1'b1;
      @(negedge clk);
      check(pc_o == 32'd4 && wb_we == 1'b0, "R1 first cycle after reset", pc_o, 32'd4);

      for (int i = 0; i < 2000 && q_st.size() != 0; i++) @(negedge clk);
      check(q_st.size() == 0, "R6 watchdog: all expected events seen", 32'(q_st.size()), 32'd0);

      // R10: halt loop repeats undefined instructions; any event is flagged by the monitor
      repeat (60) @(negedge clk);
      check(q_st.size() == 0, "R10 no event from undefined instructions", 32'(q_st.size()), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule